// File: doc/BRIEF.md
# Downlink eLink Group Serializer with Mirror Fan-out

This block turns the parallel payload of each received downlink frame into serial bit streams for front-end modules. Each group owns one 8-bit slice of the frame and four output lanes. Every 40 MHz frame, the block captures the slices and serializes them MSB-first from a 320 MHz bit clock. A group's lanes run at one of three rates: 80, 160 or 320 Mbps. The slower rates are made with holds of four or two bit-clock cycles. A faster rate leaves fewer lanes carrying data. When mirroring is on, the idle lanes repeat the streams of the active lanes, so one stream can be broadcast to several modules.

A separate control lane always runs at 80 Mbps and carries two frame bits per frame. Every data lane and the control lane has its own polarity inversion. This lets board routing swap the wires of a differential pair. The block times the frame boundary itself with a `frame_take` strobe. All data and configuration inputs are sampled only at that boundary, so a setting changed in the middle of a frame takes effect cleanly at the next frame.

Top module: `elk_down_serializer`

## Requirements
- R1: `frame_take` is high for exactly one cycle in every 8. After reset is released, the first pulse comes in the cycle that follows the 7th rising edge. `frame_data`, `ec_data`, `group_rate`, `group_mirror`, `lane_invert` and `ec_invert` are captured only on the rising edge that ends a `frame_take` cycle. Values driven at any other time have no effect on the outputs.
- R2: Call the capture edge E. Bit position j (j = 0..7, in serial order) of a captured frame is on the outputs from edge E+j+1 until edge E+j+2.
- R3: Group g takes `frame_data[8g+7:8g]` and drives `elink_out[4g+3:4g]`, where lane k is `elink_out[4g+k]`. With rate code 2'b00 (80 Mbps), lane k sends bit 7-2k and then bit 6-2k. Each bit is held for 4 positions.
- R4: With rate code 2'b01 (160 Mbps), lane 0 sends bits 7,6,5,4 and lane 2 sends bits 3,2,1,0. Each bit is held for 2 positions.
- R5: With rate code 2'b10 (320 Mbps), lane 0 sends bits 7 down to 0, one per position.
- R6: Rate code 2'b11 switches the group off. All four lanes are 0 before inversion.
- R7: With the group's mirror bit at 0, lanes that carry no stream drive 0 before inversion. These are lanes 1 and 3 at 160 Mbps, and lanes 1 to 3 at 320 Mbps.
- R8: With the mirror bit at 1, lane 1 copies lane 0 and lane 3 copies lane 2 at 160 Mbps. At 320 Mbps, all four lanes copy lane 0. At 80 Mbps the mirror bit has no effect.
- R9: Each lane's output is XORed with its own bit of `lane_invert`, after mirroring. A lane and its mirror copy can therefore have opposite polarities.
- R10: `ec_out` sends `ec_data[1]` for positions 0-3 and `ec_data[0]` for positions 4-7, XORed with `ec_invert`. Both values are captured per R1, and the timing follows R2.
- R11: While `rst_n` is low, all outputs are 0. The stored state resets to rate 80 Mbps, mirror off, no inversion and zero data, so the outputs stay 0 until the first captured frame reaches them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 320 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_data | input | N_GROUPS*GROUP_BITS | Per-group frame payload, group g at bits 8g+7:8g |
| ec_data | input | EC_BITS | Control-lane frame bits, MSB sent first |
| group_rate | input | 2*N_GROUPS | Rate code per group: 00=80, 01=160, 10=320 Mbps, 11=off |
| group_mirror | input | N_GROUPS | Mirror enable per group |
| lane_invert | input | 4*N_GROUPS | Polarity inversion per lane |
| ec_invert | input | 1 | Polarity inversion of the control lane |
| frame_take | output | 1 | High in the last cycle of a frame; inputs are captured on the edge that ends it |
| elink_out | output | 4*N_GROUPS | Serial data lanes, group g on bits 4g+3:4g |
| ec_out | output | 1 | Control lane serial output |

## Verification
The assertions check the following on every cycle, relative to the configuration that was sampled at `frame_take`:
- the 8-cycle frame period;
- the lane-to-lane copy relations of mirroring at 160 and 320 Mbps;
- the zero level of idle and switched-off lanes;
- the fact that 80 and 160 Mbps lanes and the control lane change only on their hold boundaries.

What the assertions cannot show is which payload bit lands on which lane in which position. Only the bench's reference model can check that. The same holds for the effect of inversion on mirrored copies, and for the fact that changes made in the middle of a frame leave the outputs untouched. The bench checks these against frames with mixed rates per group and against random configurations.

// File: rtl/elk_pkg.sv
package elk_pkg;

   // rate code per group; the values are part of the block's interface
   typedef enum logic [1:0] {
      RATE_80  = 2'b00,
      RATE_160 = 2'b01,
      RATE_320 = 2'b10,
      RATE_OFF = 2'b11
   } lane_rate_e;

   localparam int LANES_PER_GROUP = 4;

endpackage

// File: rtl/elk_slot_timer.sv
module elk_slot_timer #(
   parameter int SLOTS = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   output logic [$clog2(SLOTS)-1:0]   slot,
   output logic                       load
);
   localparam int SW = $clog2(SLOTS);
   localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot <= '0;
      else if (slot == LAST)
         slot <= '0;
      else
         slot <= slot + 1'b1;
   end

   // last bit slot of the frame: new frame words are taken on the edge that ends it
   assign load = (slot == LAST);

endmodule

// File: rtl/elk_lane_group.sv
module elk_lane_group
   import elk_pkg::*;
#(
   parameter int GROUP_BITS = 8,
   parameter int SW         = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [SW-1:0]               slot,
   input  logic [GROUP_BITS-1:0]       word_in,
   input  logic [1:0]                  rate_in,
   input  logic                        mirror_in,
   input  logic [LANES_PER_GROUP-1:0]  inv_in,
   output logic [LANES_PER_GROUP-1:0]  lanes
);
   localparam int TOP  = GROUP_BITS - 1;
   localparam int HALF = GROUP_BITS / 2 - 1;

   logic [GROUP_BITS-1:0]      word_q;
   lane_rate_e                 rate_q;
   logic                       mirror_q;
   logic [LANES_PER_GROUP-1:0] inv_q;
   logic [LANES_PER_GROUP-1:0] raw;

   // frame-synchronous capture of payload and settings
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q   <= '0;
         rate_q   <= RATE_80;
         mirror_q <= 1'b0;
         inv_q    <= '0;
      end else if (load) begin
         word_q   <= word_in;
         rate_q   <= lane_rate_e'(rate_in);
         mirror_q <= mirror_in;
         inv_q    <= inv_in;
      end
   end

   // bit pickers for each rate, MSB first
   logic [SW-1:0] idx_320;
   logic [SW-1:0] idx_160_hi;
   logic [SW-1:0] idx_160_lo;
   logic [SW-1:0] idx_80 [LANES_PER_GROUP];

   assign idx_320    = SW'(TOP) - slot;
   assign idx_160_hi = SW'(TOP) - {1'b0, slot[SW-1:1]};
   assign idx_160_lo = SW'(HALF) - {1'b0, slot[SW-1:1]};

   for (genvar k = 0; k < LANES_PER_GROUP; k++) begin : g_pick80
      assign idx_80[k] = SW'(TOP - 2 * k) - SW'(slot[SW-1]);
   end

   always_comb begin
      raw = '0;
      unique case (rate_q)
         RATE_80: begin
            for (int k = 0; k < LANES_PER_GROUP; k++)
               raw[k] = word_q[idx_80[k]];
         end
         RATE_160: begin
            raw[0] = word_q[idx_160_hi];
            raw[2] = word_q[idx_160_lo];
            if (mirror_q) begin
               raw[1] = raw[0];
               raw[3] = raw[2];
            end
         end
         RATE_320: begin
            raw[0] = word_q[idx_320];
            if (mirror_q)
               raw[3:1] = {3{raw[0]}};
         end
         default: raw = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lanes <= '0;
      else
         lanes <= raw ^ inv_q;
   end

endmodule

// File: rtl/elk_ec_lane.sv
module elk_ec_lane #(
   parameter int EC_BITS = 2,
   parameter int ECW     = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [ECW-1:0]     slot_hi,
   input  logic [EC_BITS-1:0] bits_in,
   input  logic               inv_in,
   output logic               lane
);
   logic [EC_BITS-1:0] bits_q;
   logic               inv_q;
   logic [ECW-1:0]     idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
         inv_q  <= 1'b0;
      end else if (load) begin
         bits_q <= bits_in;
         inv_q  <= inv_in;
      end
   end

   // the upper slot bits step once per control-lane bit period
   assign idx = ECW'(EC_BITS - 1) - slot_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lane <= 1'b0;
      else
         lane <= bits_q[idx] ^ inv_q;
   end

endmodule

// File: rtl/elk_down_serializer.sv
module elk_down_serializer
   import elk_pkg::*;
#(
   parameter int N_GROUPS   = 4,
   parameter int GROUP_BITS = 8,
   parameter int EC_BITS    = 2
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [N_GROUPS*GROUP_BITS-1:0]         frame_data,
   input  logic [EC_BITS-1:0]                     ec_data,
   input  logic [2*N_GROUPS-1:0]                  group_rate,
   input  logic [N_GROUPS-1:0]                    group_mirror,
   input  logic [N_GROUPS*LANES_PER_GROUP-1:0]    lane_invert,
   input  logic                                   ec_invert,
   output logic                                   frame_take,
   output logic [N_GROUPS*LANES_PER_GROUP-1:0]    elink_out,
   output logic                                   ec_out
);
   localparam int SW  = $clog2(GROUP_BITS);
   localparam int ECW = (EC_BITS > 1) ? $clog2(EC_BITS) : 1;

   // elaboration-time parameter checks
   if (GROUP_BITS != 8) begin : g_bad_group_bits
      $error("GROUP_BITS must be 8: four lanes over three rates need 8 slots");
   end
   if (N_GROUPS < 1) begin : g_bad_groups
      $error("N_GROUPS must be at least 1");
   end
   if (EC_BITS < 2 || EC_BITS > GROUP_BITS || (EC_BITS & (EC_BITS - 1)) != 0) begin : g_bad_ec
      $error("EC_BITS must be a power of two between 2 and GROUP_BITS");
   end

   logic [SW-1:0] slot;
   logic          load;

   elk_slot_timer #(.SLOTS(GROUP_BITS)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot),
      .load  (load)
   );

   assign frame_take = load;

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
      elk_lane_group #(.GROUP_BITS(GROUP_BITS), .SW(SW)) u_group (
         .clk       (clk),
         .rst_n     (rst_n),
         .load      (load),
         .slot      (slot),
         .word_in   (frame_data[g*GROUP_BITS +: GROUP_BITS]),
         .rate_in   (group_rate[2*g +: 2]),
         .mirror_in (group_mirror[g]),
         .inv_in    (lane_invert[g*LANES_PER_GROUP +: LANES_PER_GROUP]),
         .lanes     (elink_out[g*LANES_PER_GROUP +: LANES_PER_GROUP])
      );
   end

   elk_ec_lane #(.EC_BITS(EC_BITS), .ECW(ECW)) u_ec (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .slot_hi (slot[SW-1 -: ECW]),
      .bits_in (ec_data),
      .inv_in  (ec_invert),
      .lane    (ec_out)
   );

endmodule

// File: rtl/elk_down_serializer_chk.sv
module elk_down_serializer_chk
   import elk_pkg::*;
#(
   parameter int N_GROUPS = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [2*N_GROUPS-1:0]       group_rate,
   input logic [N_GROUPS-1:0]         group_mirror,
   input logic [4*N_GROUPS-1:0]       lane_invert,
   input logic                        frame_take,
   input logic [4*N_GROUPS-1:0]       elink_out,
   input logic                        ec_out
);
   logic [3:0]              cnt;
   logic                    take_d;
   logic [2*N_GROUPS-1:0]   a_rate, b_rate;
   logic [N_GROUPS-1:0]     a_mir, b_mir;
   logic [4*N_GROUPS-1:0]   a_inv, b_inv;

   // stage A follows the capture edge; stage B lines up with the frame on the lanes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         take_d <= 1'b0;
         a_rate <= '0;
         b_rate <= '0;
         a_mir  <= '0;
         b_mir  <= '0;
         a_inv  <= '0;
         b_inv  <= '0;
      end else begin
         take_d <= frame_take;
         if (frame_take) begin
            cnt    <= '0;
            a_rate <= group_rate;
            a_mir  <= group_mirror;
            a_inv  <= lane_invert;
         end else if (cnt != 4'hF) begin
            cnt <= cnt + 1'b1;
         end
         if (take_d) begin
            b_rate <= a_rate;
            b_mir  <= a_mir;
            b_inv  <= a_inv;
         end
      end
   end

   assert_take_period_R1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_take |-> cnt == 4'd7);
   assert_take_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == 4'd7 |-> frame_take);
   assert_reset_quiet_R11: assert property (@(posedge clk)
      !rst_n |-> (elink_out == '0 && !ec_out && !frame_take));
   assert_ec_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != 4'd1 && cnt != 4'd5) |-> $stable(ec_out));

   for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk
      logic [1:0] r;
      logic [3:0] plain;
      assign r     = b_rate[2*g +: 2];
      assign plain = elink_out[4*g +: 4] ^ b_inv[4*g +: 4];

      assert_mirror320_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (r == RATE_320 && b_mir[g]) |-> plain == {4{plain[0]}});
      assert_mirror160_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (r == RATE_160 && b_mir[g]) |-> (plain[1] == plain[0] && plain[3] == plain[2]));
      assert_idle320_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (r == RATE_320 && !b_mir[g]) |-> plain[3:1] == 3'b000);
      assert_idle160_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (r == RATE_160 && !b_mir[g]) |-> (!plain[1] && !plain[3]));
      assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
         r == RATE_OFF |-> plain == 4'b0000);
      assert_hold80_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (r == RATE_80 && cnt != 4'd1 && cnt != 4'd5) |-> $stable(elink_out[4*g +: 4]));
      assert_hold160_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (r == RATE_160 && !cnt[0]) |-> $stable(elink_out[4*g +: 4]));
   end

endmodule

bind elk_down_serializer elk_down_serializer_chk #(.N_GROUPS(N_GROUPS)) u_chk (.*);

// File: tb/elk_down_serializer_bench.sv
module elk_down_serializer_bench;

   localparam int NG     = 4;
   localparam int N_CYC  = 12000;

   typedef struct packed {
      logic [31:0] d;
      logic [1:0]  ec;
      logic [7:0]  rate;
      logic [3:0]  mir;
      logic [15:0] inv;
      logic        ecinv;
   } frm_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] frame_data;
   logic [1:0]  ec_data;
   logic [7:0]  group_rate;
   logic [3:0]  group_mirror;
   logic [15:0] lane_invert;
   logic        ec_invert;
   logic        frame_take;
   logic [15:0] elink_out;
   logic        ec_out;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   elk_down_serializer u_elk_down_serializer (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_data   (frame_data),
      .ec_data      (ec_data),
      .group_rate   (group_rate),
      .group_mirror (group_mirror),
      .lane_invert  (lane_invert),
      .ec_invert    (ec_invert),
      .frame_take   (frame_take),
      .elink_out    (elink_out),
      .ec_out       (ec_out)
   );

   task automatic note(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference lane pattern of one group for serial position j (R3..R9)
   function automatic logic [3:0] exp_group(input logic [7:0] w, input logic [1:0] r,
                                            input logic m, input logic [3:0] inv, input int j);
      logic [3:0] raw;
      logic [7:0] t;
      raw = 4'b0000;
      case (r)
         2'b00: begin
            for (int k = 0; k < 4; k++) begin
               t = w >> (7 - 2 * k - j / 4);
               raw = raw | (4'(t[0]) << k);
            end
         end
         2'b01: begin
            t = w >> (7 - j / 2);
            raw = raw | 4'(t[0]);
            t = w >> (3 - j / 2);
            raw = raw | (4'(t[0]) << 2);
            if (m) raw = raw | (raw << 1);
         end
         2'b10: begin
            t = w >> (7 - j);
            raw = t[0] ? (m ? 4'b1111 : 4'b0001) : 4'b0000;
         end
         default: raw = 4'b0000;
      endcase
      return raw ^ inv;
   endfunction

   function automatic string tag_of(input logic [1:0] r, input logic m, input logic [3:0] inv);
      string s;
      case (r)
         2'b00:   s = m ? "R2 R3 R8" : "R2 R3";
         2'b01:   s = m ? "R2 R4 R8" : "R2 R4 R7";
         2'b10:   s = m ? "R2 R5 R8" : "R2 R5 R7";
         default: s = "R2 R6";
      endcase
      if (inv != 4'b0000) s = {s, " R9"};
      return s;
   endfunction

   frm_t cur, pend;
   int   nfr = 0;

   task automatic check_outputs(input int j);
      logic [3:0] e;
      logic       ee;
      logic [1:0] es;
      for (int g = 0; g < NG; g++) begin
         e = exp_group(cur.d[8*g +: 8], cur.rate[2*g +: 2], cur.mir[g], cur.inv[4*g +: 4], j);
         note(elink_out[4*g +: 4] === e,
              (nfr == 0) ? "R11" : tag_of(cur.rate[2*g +: 2], cur.mir[g], cur.inv[4*g +: 4]),
              32'(elink_out[4*g +: 4]), 32'(e));
      end
      es = cur.ec >> (1 - j / 4);
      ee = es[0] ^ cur.ecinv;
      note(ec_out === ee, "R10", 32'(ec_out), 32'(ee));
   endtask

   task automatic pick_frame(input int n, output frm_t f);
      f.d     = $urandom();
      f.ec    = 2'($urandom());
      f.rate  = 8'($urandom());
      f.mir   = 4'($urandom());
      f.inv   = 16'($urandom());
      f.ecinv = 1'($urandom());
      case (n)
         0:  begin f.rate = 8'h00; f.mir = 4'h0; f.inv = 16'h0; f.d = 32'hA5C3_96F0; f.ec = 2'b10; f.ecinv = 1'b0; end
         1:  begin f.rate = 8'h55; f.mir = 4'h0; f.inv = 16'h0; end
         2:  begin f.rate = 8'h55; f.mir = 4'hF; f.inv = 16'h0; end
         3:  begin f.rate = 8'hAA; f.mir = 4'h0; f.inv = 16'h0; end
         4:  begin f.rate = 8'hAA; f.mir = 4'hF; f.inv = 16'h0; end
         5:  begin f.rate = 8'hFF; f.inv = 16'h0; end
         6:  begin f.rate = 8'h00; f.mir = 4'hF; f.inv = 16'h0; end
         7:  begin f.rate = 8'hAA; f.mir = 4'hF; f.inv = 16'h5A3C; end
         8:  begin f.rate = 8'b11_10_01_00; f.mir = 4'hF; f.inv = 16'h0; end
         9:  begin f.rate = 8'h00; f.d = 32'hFFFF_FFFF; f.inv = 16'hFFFF; f.ec = 2'b11; f.ecinv = 1'b1; end
         10: begin f.rate = 8'h55; f.d = 32'h0; f.mir = 4'hF; f.inv = 16'hFFFF; end
         default: ;
      endcase
   endtask

   task automatic drive(input frm_t f);
      frame_data   = f.d;
      ec_data      = f.ec;
      group_rate   = f.rate;
      group_mirror = f.mir;
      lane_invert  = f.inv;
      ec_invert    = f.ecinv;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      int  since;
      int  k;
      bit  cap_flag;
      void'($urandom(32'd5150));
      cur  = '0;
      pend = '0;
      rst_n = 1'b0;
      drive('0);
      // R11: quiet outputs while reset is held
      repeat (4) begin
         @(negedge clk);
         note(elink_out === 16'h0 && ec_out === 1'b0 && frame_take === 1'b0, "R11",
              {15'h0, frame_take, elink_out}, 32'h0);
      end
      rst_n = 1'b1;
      since = 1;
      k = 0;
      cap_flag = 1'b0;
      for (int cyc = 0; cyc < N_CYC; cyc++) begin
         @(negedge clk);
         since++;
         // R1: one strobe per eight cycles, first one after the seventh edge
         note(frame_take === (since % 8 == 0), "R1", 32'(frame_take), 32'(since % 8 == 0));
         if (cap_flag) begin
            check_outputs(7);
            cur = pend;
            k = 0;
            cap_flag = 1'b0;
         end else begin
            if (k < 7) k++;
            check_outputs((k == 0) ? 0 : k - 1);
         end
         if (frame_take) begin
            pick_frame(nfr, pend);
            nfr++;
            drive(pend);
            cap_flag = 1'b1;
         end else if (k == 3 && (nfr % 2) == 1) begin
            frm_t junk;
            // R1: mid-frame input changes must not reach the lanes
            pick_frame(1000, junk);
            drive(junk);
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule